// File: doc/BRIEF.md
# Exponential Retry Backoff Controller

This block paces the retries of a contended compare-and-swap. Each time the tracked operation fails, the block asks a stall unit for one wait. The length of that wait is the current spin count scaled into cycles, at 128 cycles per unit. After each request the spin count doubles for the next failure, until it reaches a ceiling.

The whole budget goes out as a single request. The block does not issue a run of short fixed waits. The stall unit answers with `wait_done`. Until that answer arrives, no further request is made. A failure reported during the wait is remembered and served once the wait ends. Starting a new operation or reporting success returns the spin count to its initial value.

Top module: `backoff_ctrl`

## Requirements
- R1: While and just after reset, `wait_req` and `busy` are 0 and `wait_cycles` is 0.
- R2: An `op_fail` seen while no wait is outstanding gives a `wait_req` pulse exactly one cycle long, in the following cycle.
- R3: `wait_cycles` equals the spin count times 128 (the count shifted left by 7). It is valid in the cycle of `wait_req` and is held unchanged until the next request.
- R4: The spin count is 1 after reset, after `start` and after `op_success`. Every issued request doubles it for the next one, so successive budgets are 128, 256, 512 and so on.
- R5: The spin count never exceeds 4096. Once it reaches 4096, every later budget is 524288.
- R6: From a `wait_req` until the cycle in which `wait_done` is seen, no new `wait_req` is issued.
- R7: An `op_fail` that arrives during an outstanding wait is held. Its request pulses in the cycle after `wait_done`. Several such failures collapse into one request.
- R8: `busy` rises in the cycle after a failure is accepted or held. It falls in the cycle after `start` or `op_success`.
- R9: Within one cycle, `start` wins over `op_success`, which wins over `op_fail`. Both `start` and `op_success` discard a held failure, and neither issues a request.
- R10: When `wait_done` and `op_fail` arrive in the same cycle, the request is issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | A new operation begins; resets the spin count |
| op_fail | input | 1 | The tracked compare-and-swap failed |
| op_success | input | 1 | The tracked compare-and-swap succeeded |
| wait_done | input | 1 | The stall unit finished the outstanding wait |
| wait_req | output | 1 | One-cycle request to the stall unit |
| wait_cycles | output | 20 | Stall budget in cycles, valid with `wait_req` |
| busy | output | 1 | An operation is in backoff, from first failure until success |

## Verification
The design is tried with several input patterns:
- A chain of failures, each followed by a prompt `wait_done`. The budget must climb by doubling and then flatten at the ceiling, which separates correct saturation from wrap-around or an early stop.
- A burst of failures inside one wait. This must yield exactly one late request, which separates holding from dropping and from double issue.
- A failure that coincides with `wait_done`, which tests the release boundary.
- Collisions of `start`, `op_success` and `op_fail` in one cycle, plus a success that arrives during a wait. These show the priority order, and they show that a held failure is discarded rather than served.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_ISSUE = 2'd2,
        ACT_HOLD  = 2'd3
    } backoff_act_e;

endpackage

// File: rtl/backoff_decide.sv
module backoff_decide
    import backoff_pkg::*;
(
    input  logic         start,
    input  logic         op_fail,
    input  logic         op_success,
    input  logic         wait_done,
    input  logic         waiting,
    input  logic         held,
    output backoff_act_e act
);
    logic blocked;

    always_comb begin
        blocked = waiting && !wait_done;
        if (start || op_success) begin
            act = ACT_CLEAR;
        end else if ((op_fail || held) && !blocked) begin
            act = ACT_ISSUE;
        end else if (op_fail) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_IDLE;
        end
    end
endmodule

// File: rtl/backoff_step.sv
module backoff_step #(
    parameter int LIMIT = 4096,
    parameter int CNT_W = 13
) (
    input  logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] HALF = CNT_W'((LIMIT + 1) / 2);

    always_comb begin
        if (cur >= HALF) begin
            nxt = LIM;
        end else begin
            nxt = {cur[CNT_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/backoff_scale.sv
module backoff_scale #(
    parameter int CNT_W = 13,
    parameter int SHIFT = 7,
    localparam int BUD_W = CNT_W + SHIFT
) (
    input  logic [CNT_W-1:0] count,
    output logic [BUD_W-1:0] budget
);
    generate
        if (SHIFT == 0) begin : g_noscale
            assign budget = count;
        end else begin : g_scale
            assign budget = {count, {SHIFT{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl
    import backoff_pkg::*;
#(
    parameter int SPIN_INIT  = 1,
    parameter int SPIN_LIMIT = 4096,
    parameter int UNIT_SHIFT = 7,
    localparam int CNT_W = $clog2(SPIN_LIMIT + 1),
    localparam int BUD_W = CNT_W + UNIT_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_fail,
    input  logic             op_success,
    input  logic             wait_done,
    output logic             wait_req,
    output logic [BUD_W-1:0] wait_cycles,
    output logic             busy
);
    localparam logic [CNT_W-1:0] INIT = CNT_W'(SPIN_INIT);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             waiting;
        logic             held;
        logic             busy;
        logic             req;
        logic [BUD_W-1:0] budget;
    } state_t;

    state_t       st_d, st_q;
    backoff_act_e act;
    logic [CNT_W-1:0] count_nxt;
    logic [BUD_W-1:0] budget_now;

    backoff_decide u_decide (
        .start      (start),
        .op_fail    (op_fail),
        .op_success (op_success),
        .wait_done  (wait_done),
        .waiting    (st_q.waiting),
        .held       (st_q.held),
        .act        (act)
    );

    backoff_step #(.LIMIT(SPIN_LIMIT), .CNT_W(CNT_W)) u_step (
        .cur (st_q.count),
        .nxt (count_nxt)
    );

    backoff_scale #(.CNT_W(CNT_W), .SHIFT(UNIT_SHIFT)) u_scale (
        .count  (st_q.count),
        .budget (budget_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (wait_done) begin
            st_d.waiting = 1'b0;
        end
        case (act)
            ACT_CLEAR: begin
                st_d.count = INIT;
                st_d.held  = 1'b0;
                st_d.busy  = 1'b0;
            end
            ACT_ISSUE: begin
                st_d.req     = 1'b1;
                st_d.budget  = budget_now;
                st_d.count   = count_nxt;
                st_d.waiting = 1'b1;
                st_d.held    = 1'b0;
                st_d.busy    = 1'b1;
            end
            ACT_HOLD: begin
                st_d.held = 1'b1;
                st_d.busy = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count   <= INIT;
            st_q.waiting <= 1'b0;
            st_q.held    <= 1'b0;
            st_q.busy    <= 1'b0;
            st_q.req     <= 1'b0;
            st_q.budget  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wait_req    = st_q.req;
    assign wait_cycles = st_q.budget;
    assign busy        = st_q.busy;
endmodule

// File: rtl/backoff_ctrl_chk.sv
module backoff_ctrl_chk #(
    parameter int SPIN_LIMIT = 4096,
    parameter int UNIT_SHIFT = 7,
    parameter int BUD_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_fail,
    input logic             op_success,
    input logic             wait_done,
    input logic             waiting,
    input logic             wait_req,
    input logic [BUD_W-1:0] wait_cycles,
    input logic             busy
);
    localparam logic [BUD_W-1:0] MAX_BUD = BUD_W'(SPIN_LIMIT) << UNIT_SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!wait_req && !busy && wait_cycles == '0)
                else $error("reset outputs not quiet");
        end
    end

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> !wait_req);

    p_hold_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req |-> $stable(wait_cycles));

    p_power_of_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wait_cycles) <= 1);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cycles <= MAX_BUD);

    p_no_req_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !wait_done) |=> !wait_req);

    p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fail && !start && !op_success) |=> busy);

    p_clear_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start || op_success) |=> (!busy && !wait_req));
endmodule

bind backoff_ctrl backoff_ctrl_chk #(
    .SPIN_LIMIT (SPIN_LIMIT),
    .UNIT_SHIFT (UNIT_SHIFT),
    .BUD_W      (BUD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_fail     (op_fail),
    .op_success  (op_success),
    .wait_done   (wait_done),
    .waiting     (st_q.waiting),
    .wait_req    (wait_req),
    .wait_cycles (wait_cycles),
    .busy        (busy)
);

// File: tb/sim_backoff_ctrl.sv
module sim_backoff_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BUD_W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, op_fail = 1'b0, op_success = 1'b0, wait_done = 1'b0;
    logic wait_req, busy;
    logic [BUD_W-1:0] wait_cycles;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    integer m_count = 1, m_cyc = 0;
    bit m_wait = 0, m_held = 0, m_busy = 0, m_req = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    backoff_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_fail(op_fail),
        .op_success(op_success), .wait_done(wait_done),
        .wait_req(wait_req), .wait_cycles(wait_cycles), .busy(busy)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            bit fire;
            fire = 0;
            if (start || op_success) begin
                m_count = 1; m_held = 0; m_busy = 0;
            end else if ((op_fail || m_held) && !(m_wait && !wait_done)) begin
                fire = 1;
                m_cyc = m_count * 128;
                m_count = (m_count * 2 > 4096) ? 4096 : m_count * 2;
                m_held = 0; m_busy = 1;
            end else if (op_fail) begin
                m_held = 1; m_busy = 1;
            end
            if (fire) m_wait = 1;
            else if (wait_done) m_wait = 0;
            m_req = fire;
        end
    end

    task automatic check(input string t, input string what, input integer act, input integer exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, "wait_req", wait_req, m_req);
            check(tag, "wait_cycles", wait_cycles, m_cyc);
            check(tag, "busy", busy, m_busy);
        end
    end

    task automatic drv(input bit st, input bit f, input bit s, input bit d);
        @(negedge clk);
        #1;
        start = st; op_fail = f; op_success = s; wait_done = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(0, 0, 0, 0);
    endtask

    task automatic fail_then_done();
        drv(0, 1, 0, 0);
        idle(2);
        drv(0, 0, 0, 1);
        drv(0, 0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "wait_req", wait_req, 0);
        check("R1", "busy", busy, 0);
        check("R1", "wait_cycles", wait_cycles, 0);
        #1 rst_n = 1'b1;
        idle(2);

        // R2 R3 R4 doubling chain
        tag = "R2_R3_R4";
        drv(1, 0, 0, 0);
        for (int k = 0; k < 3; k++) fail_then_done();
        check("R4", "third budget", wait_cycles, 512);

        // R8 success resets count
        tag = "R8";
        drv(0, 0, 1, 0);
        idle(1);
        check("R8", "busy after success", busy, 0);
        tag = "R4";
        fail_then_done();
        check("R4", "budget after success", wait_cycles, 128);

        // R5 saturation
        tag = "R5";
        drv(1, 0, 0, 0);
        for (int k = 0; k < 15; k++) fail_then_done();
        check("R5", "capped budget", wait_cycles, 524288);

        // R7 held failures collapse
        tag = "R7";
        drv(1, 0, 0, 0);
        drv(0, 1, 0, 0);
        drv(0, 1, 0, 0);
        drv(0, 1, 0, 0);
        drv(0, 0, 0, 0);
        drv(0, 0, 0, 1);
        drv(0, 0, 0, 0);
        check("R7", "held request", wait_req, 1);
        check("R7", "held budget", wait_cycles, 256);
        idle(1);
        drv(0, 0, 0, 1);

        // R6 repeated failures while waiting
        tag = "R6";
        drv(0, 1, 0, 0);
        for (int k = 0; k < 5; k++) drv(0, 1, 0, 0);
        drv(0, 0, 0, 1);
        idle(2);
        drv(0, 0, 0, 1);

        // R10 fail coinciding with wait_done
        tag = "R10";
        drv(0, 1, 0, 0);
        idle(2);
        drv(0, 1, 0, 1);
        drv(0, 0, 0, 0);
        check("R10", "request after done+fail", wait_req, 1);
        idle(1);
        drv(0, 0, 0, 1);

        // R9 priority and discard of held failure
        tag = "R9";
        drv(0, 1, 1, 0);
        drv(1, 1, 1, 0);
        drv(0, 0, 0, 0);
        check("R9", "no request on collision", wait_req, 0);
        drv(0, 1, 0, 0);
        drv(0, 1, 0, 0);
        drv(0, 0, 1, 0);
        drv(0, 0, 0, 1);
        drv(0, 0, 0, 0);
        check("R9", "held failure discarded", wait_req, 0);
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule